// File: doc/BRIEF.md
# I2C Master Byte Transfer Sequencer

This block sequences master-side byte transfers for an I2C controller. Host software programs a control word, a 7-bit target address and a byte count. The sequencer then sends the operations a transfer needs, one at a time, to a byte-level bus engine: address phase (start), byte send, byte receive and stop. The engine answers each operation with an acknowledge pulse and an ACK/NACK flag. The sequencer does not store data. The fill levels of the transmit and receive FIFOs come in as inputs. The sequencer pulses `tx_pop` or `rx_push` for each byte that moves.

There are two ways to run a transfer. In count mode, a remaining-byte counter is loaded from the programmed count when the address phase is acknowledged, and it drops by one for each data byte. At terminal count the sequencer issues a stop if stop was requested. If stop was not requested, it reports access-ready and releases master mode, leaving the bus held. In repeat mode the counter is ignored. Bytes move while the FIFO allows, and a stop request is served at once. The start and stop command bits clear themselves, and a NACK cancels a pending stop.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset the control word reads 0, the remaining count reads 0, no engine request is raised and the bus is not held.
- R2: A control write keeps only the writable bits of mask 0xCF07. The bits are: go (bit 0), stop request (bit 1), repeat mode (bit 2), ten-bit address (bit 8), transmit (bit 9), master (bit 10), bit 11, bit 14 and enable (bit 15). The stored word reads back on `ctl_q`.
- R3: A control write with enable (bit 15) clear clears the control word, the programmed count, the remaining count and the address, and releases the bus.
- R4: With enable and master set and ten-bit clear, a set go bit requests a start (eng_op 0) to the stored address. The request has `eng_rd` equal to NOT transmit. When the start is acknowledged, the go bit clears, the bus becomes held and the remaining count loads from the programmed count.
- R5: A control write with master clear, or with ten-bit set, is stored as written but issues no engine request.
- R6: A NACKed start pulses `ev_nack`, clears go and stop request, and leaves the bus released with no data operation.
- R7: In count mode with transmit set, one send (eng_op 1) and one `tx_pop` happen per byte while the remaining count is nonzero and `tx_level` is nonzero. Each byte lowers the remaining count by one. The sequencer waits while the FIFO is empty.
- R8: In count mode with transmit clear, one receive (eng_op 2) happens per byte while the remaining count is nonzero and `rx_level` is below the FIFO depth. The sequencer resumes when the level drops.
- R9: At terminal count with stop request set, the sequencer issues a stop (eng_op 3), clears stop request, releases the bus and reloads the remaining count from the programmed count.
- R10: At terminal count with stop request clear, the sequencer pulses `ev_ardy` once, clears master and issues no stop.
- R11: In repeat mode, sends run until `tx_level` is 0 whatever the count, and the remaining count is left unchanged. A set stop request issues a stop at once and then clears.
- R12: A NACKed data byte pulses `ev_nack`, clears stop request and blocks further data operations until the next start.
- R13: Only one engine operation is outstanding at a time. `eng_req` and `eng_op` hold steady until `eng_ack`, and the next decision waits until the FIFO levels have settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cnt_wr | input | 1 | Byte count write strobe |
| cnt_wdata | input | 16 | Programmed byte count |
| addr_wr | input | 1 | Target address write strobe |
| addr_wdata | input | 7 | Target address |
| tx_level | input | 3 | Bytes waiting in the transmit FIFO |
| rx_level | input | 3 | Bytes held in the receive FIFO |
| ctl_q | output | 16 | Stored control word |
| remain_q | output | 16 | Remaining byte count |
| bus_held | output | 1 | The address phase succeeded and no stop has followed |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| eng_addr | output | 7 | Target address for a start |
| eng_rd | output | 1 | Read direction for a start |
| eng_ack | input | 1 | Engine completed the operation |
| eng_nack | input | 1 | Completed operation was not acknowledged |
| tx_pop | output | 1 | One byte taken from the transmit FIFO |
| rx_push | output | 1 | One byte placed in the receive FIFO |
| ev_ardy | output | 1 | Access-ready pulse |
| ev_nack | output | 1 | NACK pulse |
| ev_xrdy | output | 1 | Byte sent and acknowledged |
| ev_rrdy | output | 1 | Byte received |

## Verification
Each transmit and receive run stalls on a FIFO boundary partway through the count, so a design that ignored the level would overrun the FIFO, and one that dropped the count would never reach terminal count. Both terminal-count outcomes are covered. A design that swapped them would issue a stop where access-ready was due, or leave master set. The bench NACKs a start and a second data byte. A design that kept the stop request or kept sending would show an extra stop or extra sends. Repeat mode runs with a zero count, which catches a design that still obeys the count. A disable write is followed by a new start, which exposes any count or address that survived the clear.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_WAIT   = 2'd1,
        LK_SETTLE = 2'd2
    } link_st_e;

    localparam logic [15:0] CTL_WMASK = 16'hCF07;

    typedef struct packed {
        logic       en;
        logic       be;
        logic [1:0] rsvd_hi;
        logic       aux;
        logic       mst;
        logic       trx;
        logic       xa;
        logic [4:0] rsvd_lo;
        logic       rm;
        logic       stp;
        logic       stt;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [15:0] w);
        return ctl_t'(w & CTL_WMASK);
    endfunction

    function automatic logic op_is_data(input bus_op_e op);
        return (op == OP_SEND) || (op == OP_RECV);
    endfunction

endpackage

// File: rtl/i2c_seq_pick.sv
module i2c_seq_pick
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             en,
    input  logic             mst,
    input  logic             xa,
    input  logic             stt,
    input  logic             stp,
    input  logic             rm,
    input  logic             trx,
    input  logic             hold,
    input  logic             halt,
    input  logic [CNT_W-1:0] remain,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             go,
    output bus_op_e          op,
    output logic             ardy
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic active;
    logic tx_ok;
    logic rx_ok;

    assign active = en && mst && hold;
    assign tx_ok  = trx && (tx_level != '0) && !halt;
    assign rx_ok  = !trx && (rx_level < FULL_LVL) && !halt;

    always_comb begin
        go   = 1'b0;
        op   = OP_START;
        ardy = 1'b0;
        if (en && mst && !xa && stt) begin
            go = 1'b1;
            op = OP_START;
        end else if (active) begin
            if (rm || halt) begin
                if (stp) begin
                    go = 1'b1;
                    op = OP_STOP;
                end else if (tx_ok) begin
                    go = 1'b1;
                    op = OP_SEND;
                end else if (rx_ok) begin
                    go = 1'b1;
                    op = OP_RECV;
                end
            end else if (remain != '0) begin
                if (tx_ok) begin
                    go = 1'b1;
                    op = OP_SEND;
                end else if (rx_ok) begin
                    go = 1'b1;
                    op = OP_RECV;
                end
            end else if (stp) begin
                go = 1'b1;
                op = OP_STOP;
            end else begin
                ardy = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_seq_link.sv
module i2c_seq_link
    import i2c_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    input  bus_op_e op_in,
    input  logic    eng_ack,
    output logic    idle,
    output logic    eng_req,
    output bus_op_e op_q,
    output logic    done
);
    link_st_e st;

    assign idle = (st == LK_IDLE);
    assign done = (st == LK_WAIT) && eng_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LK_IDLE;
            eng_req <= 1'b0;
            op_q    <= OP_START;
        end else begin
            case (st)
                LK_IDLE: begin
                    if (go) begin
                        eng_req <= 1'b1;
                        op_q    <= op_in;
                        st      <= LK_WAIT;
                    end
                end
                LK_WAIT: begin
                    if (eng_ack) begin
                        eng_req <= 1'b0;
                        st      <= LK_SETTLE;
                    end
                end
                default: st <= LK_IDLE;
            endcase
        end
    end

    // R13: request and operation stay put until the engine answers
    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack) |=> (eng_req && $stable(op_q)));

    // R13: a new request never follows a completion directly
    a_r13_settle_gap: assert property (@(posedge clk) disable iff (rst)
        done |=> !eng_req);
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 7,
    parameter int FIFO_DEPTH = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [15:0]       ctl_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [15:0]       ctl_q,
    output logic [CNT_W-1:0]  remain_q,
    output logic              bus_held,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_rd,
    input  logic              eng_ack,
    input  logic              eng_nack,
    output logic              tx_pop,
    output logic              rx_push,
    output logic              ev_ardy,
    output logic              ev_nack,
    output logic              ev_xrdy,
    output logic              ev_rrdy
);
    ctl_t             ctl_r;
    ctl_t             wr_ctl;
    logic [CNT_W-1:0] cnt_r;
    logic [ADDR_W-1:0] addr_r;
    logic             hold_r;
    logic             halt_r;
    logic             pick_go;
    logic             pick_ardy;
    bus_op_e          pick_op;
    logic             lk_idle;
    logic             lk_done;
    bus_op_e          lk_op;

    assign wr_ctl   = ctl_from_word(ctl_wdata);
    assign ctl_q    = ctl_r;
    assign bus_held = hold_r;
    assign eng_op   = lk_op;
    assign eng_addr = addr_r;
    assign eng_rd   = !ctl_r.trx;

    i2c_seq_pick #(
        .CNT_W      (CNT_W),
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W)
    ) u_pick (
        .en       (ctl_r.en),
        .mst      (ctl_r.mst),
        .xa       (ctl_r.xa),
        .stt      (ctl_r.stt),
        .stp      (ctl_r.stp),
        .rm       (ctl_r.rm),
        .trx      (ctl_r.trx),
        .hold     (hold_r),
        .halt     (halt_r),
        .remain   (remain_q),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .go       (pick_go),
        .op       (pick_op),
        .ardy     (pick_ardy)
    );

    i2c_seq_link u_link (
        .clk     (clk),
        .rst     (rst),
        .go      (pick_go),
        .op_in   (pick_op),
        .eng_ack (eng_ack),
        .idle    (lk_idle),
        .eng_req (eng_req),
        .op_q    (lk_op),
        .done    (lk_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r    <= '0;
            cnt_r    <= '0;
            remain_q <= '0;
            addr_r   <= '0;
            hold_r   <= 1'b0;
            halt_r   <= 1'b0;
            tx_pop   <= 1'b0;
            rx_push  <= 1'b0;
            ev_ardy  <= 1'b0;
            ev_nack  <= 1'b0;
            ev_xrdy  <= 1'b0;
            ev_rrdy  <= 1'b0;
        end else begin
            tx_pop  <= 1'b0;
            rx_push <= 1'b0;
            ev_ardy <= 1'b0;
            ev_nack <= 1'b0;
            ev_xrdy <= 1'b0;
            ev_rrdy <= 1'b0;
            if (cnt_wr)  cnt_r  <= cnt_wdata;
            if (addr_wr) addr_r <= addr_wdata;
            if (ctl_wr && !wr_ctl.en) begin
                ctl_r    <= '0;
                cnt_r    <= '0;
                remain_q <= '0;
                addr_r   <= '0;
                hold_r   <= 1'b0;
                halt_r   <= 1'b0;
            end else begin
                if (lk_done) begin
                    case (lk_op)
                        OP_START: begin
                            ctl_r.stt <= 1'b0;
                            if (eng_nack) begin
                                ev_nack   <= 1'b1;
                                ctl_r.stp <= 1'b0;
                                hold_r    <= 1'b0;
                            end else begin
                                hold_r   <= 1'b1;
                                halt_r   <= 1'b0;
                                remain_q <= cnt_r;
                            end
                        end
                        OP_SEND: begin
                            tx_pop <= 1'b1;
                            if (!ctl_r.rm) remain_q <= remain_q - CNT_W'(1);
                            if (eng_nack) begin
                                ev_nack   <= 1'b1;
                                ctl_r.stp <= 1'b0;
                                halt_r    <= 1'b1;
                            end else begin
                                ev_xrdy <= 1'b1;
                            end
                        end
                        OP_RECV: begin
                            rx_push <= 1'b1;
                            ev_rrdy <= 1'b1;
                            if (!ctl_r.rm) remain_q <= remain_q - CNT_W'(1);
                        end
                        default: begin
                            ctl_r.stp <= 1'b0;
                            hold_r    <= 1'b0;
                            remain_q  <= cnt_r;
                        end
                    endcase
                end else if (lk_idle && pick_ardy) begin
                    ev_ardy   <= 1'b1;
                    ctl_r.mst <= 1'b0;
                end
                if (ctl_wr) ctl_r <= wr_ctl;
            end
        end
    end

    // R6 / R12: a NACK pulse leaves no stop request behind
    a_r6_nack_drops_stop: assert property (@(posedge clk) disable iff (rst)
        (ev_nack && !$past(ctl_wr)) |-> !ctl_r.stp);

    // R10: access-ready comes with master released
    a_r10_ardy_drops_master: assert property (@(posedge clk) disable iff (rst)
        (ev_ardy && !$past(ctl_wr)) |-> !ctl_r.mst);

    // R7 / R8: count mode never launches a data byte from a zero count
    a_r7_no_data_at_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(eng_req) && op_is_data(lk_op) && !$past(ctl_r.rm) && !$past(halt_r))
            |-> ($past(remain_q) != '0));

    // R12: after a data NACK only start or stop reach the engine
    a_r12_halt_blocks_data: assert property (@(posedge clk) disable iff (rst)
        ($rose(eng_req) && $past(halt_r)) |-> !op_is_data(lk_op));

    // R7: a pop only follows a send
    a_r7_pop_after_send: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> ($past(lk_op) == OP_SEND));
endmodule

// File: tb/i2c_byte_seq_test.sv
module i2c_byte_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        addr_wr = 1'b0;
    logic [6:0]  addr_wdata = '0;
    logic [2:0]  tx_level = '0;
    logic [2:0]  rx_level = '0;
    logic [15:0] ctl_q;
    logic [15:0] remain_q;
    logic        bus_held;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [6:0]  eng_addr;
    logic        eng_rd;
    logic        eng_ack = 1'b0;
    logic        eng_nack = 1'b0;
    logic        tx_pop, rx_push, ev_ardy, ev_nack, ev_xrdy, ev_rrdy;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
    int n_ardy = 0, n_nack = 0;
    int last_addr = 0, last_rd = 0;
    bit nack_start = 1'b0;
    int nack_send_at = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_seq uut (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .ctl_q(ctl_q), .remain_q(remain_q), .bus_held(bus_held),
        .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_rd(eng_rd),
        .eng_ack(eng_ack), .eng_nack(eng_nack),
        .tx_pop(tx_pop), .rx_push(rx_push),
        .ev_ardy(ev_ardy), .ev_nack(ev_nack), .ev_xrdy(ev_xrdy), .ev_rrdy(ev_rrdy)
    );

    // engine and FIFO model, acting on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (tx_pop && tx_level != 0) tx_level = tx_level - 3'd1;
            if (rx_push) rx_level = rx_level + 3'd1;
            if (ev_ardy) n_ardy++;
            if (ev_nack) n_nack++;
            if (eng_ack) begin
                eng_ack  = 1'b0;
                eng_nack = 1'b0;
            end else if (eng_req) begin
                case (eng_op)
                    2'd0: begin
                        n_start++;
                        last_addr = int'(eng_addr);
                        last_rd   = int'(eng_rd);
                        eng_nack  = nack_start;
                    end
                    2'd1: begin
                        n_send++;
                        eng_nack = (n_send == nack_send_at);
                    end
                    2'd2: n_recv++;
                    default: n_stop++;
                endcase
                eng_ack = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic put_ctl(input logic [15:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic put_cnt(input logic [15:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic put_addr(input logic [6:0] v);
        @(negedge clk); addr_wr = 1'b1; addr_wdata = v;
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic quiet();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_eq("R1", "ctl in reset", int'(ctl_q), 0);
        chk_eq("R1", "remain in reset", int'(remain_q), 0);
        chk_eq("R1", "req in reset", int'(eng_req), 0);
        chk_eq("R1", "held in reset", int'(bus_held), 0);
        @(negedge clk); rst = 1'b0;
        quiet();
        chk_eq("R1", "no op after reset", n_start + n_send + n_recv + n_stop, 0);
    endtask

    task automatic t_mask();
        put_ctl(16'hFFF8);
        quiet();
        chk_eq("R2", "masked readback", int'(ctl_q), 16'hCF00);
        chk_eq("R2", "no op from mask write", n_start, 0);
        put_ctl(16'h0000);
    endtask

    task automatic t_no_start();
        int s0 = n_start;
        put_ctl(16'h8001);
        quiet();
        chk_eq("R5", "stored without master", int'(ctl_q), 16'h8001);
        chk_eq("R5", "no start without master", n_start - s0, 0);
        put_ctl(16'h8501);
        quiet();
        chk_eq("R5", "stored with ten-bit", int'(ctl_q), 16'h8501);
        chk_eq("R5", "no start with ten-bit", n_start - s0, 0);
        put_ctl(16'h0000);
    endtask

    task automatic t_tx_count_stop();
        int s0 = n_send, p0 = n_stop, a0 = n_ardy;
        put_addr(7'h52);
        put_cnt(16'd3);
        tx_level = 3'd2;
        put_ctl(16'h8603);
        quiet();
        chk_eq("R4", "start address", last_addr, 16'h52);
        chk_eq("R4", "write direction", last_rd, 0);
        chk_eq("R7", "sends before empty", n_send - s0, 2);
        chk_eq("R7", "remain after two", int'(remain_q), 1);
        chk_eq("R4", "go bit cleared", int'(ctl_q), 16'h8602);
        tx_level = 3'd1;
        quiet();
        chk_eq("R7", "sends total", n_send - s0, 3);
        chk_eq("R9", "one stop", n_stop - p0, 1);
        chk_eq("R9", "remain reloaded", int'(remain_q), 3);
        chk_eq("R9", "stop bit cleared", int'(ctl_q), 16'h8600);
        chk_eq("R9", "bus released", int'(bus_held), 0);
        chk_eq("R9", "no ardy", n_ardy - a0, 0);
        put_ctl(16'h0000);
    endtask

    task automatic t_rx_count_ardy();
        int r0 = n_recv, p0 = n_stop, a0 = n_ardy;
        put_addr(7'h21);
        put_cnt(16'd5);
        rx_level = 3'd0;
        put_ctl(16'h8401);
        quiet();
        chk_eq("R4", "read direction", last_rd, 1);
        chk_eq("R8", "receives until full", n_recv - r0, 4);
        chk_eq("R8", "remain at stall", int'(remain_q), 1);
        rx_level = 3'd0;
        quiet();
        chk_eq("R8", "receives total", n_recv - r0, 5);
        chk_eq("R10", "one ardy", n_ardy - a0, 1);
        chk_eq("R10", "master cleared", int'(ctl_q), 16'h8000);
        chk_eq("R10", "no stop", n_stop - p0, 0);
        put_ctl(16'h0000);
        rx_level = 3'd0;
    endtask

    task automatic t_start_nack();
        int s0 = n_send, k0 = n_nack, t0 = n_start;
        put_cnt(16'd2);
        tx_level = 3'd2;
        nack_start = 1'b1;
        put_ctl(16'h8603);
        quiet();
        nack_start = 1'b0;
        chk_eq("R6", "start issued", n_start - t0, 1);
        chk_eq("R6", "nack pulse", n_nack - k0, 1);
        chk_eq("R6", "go and stop cleared", int'(ctl_q), 16'h8600);
        chk_eq("R6", "no sends", n_send - s0, 0);
        chk_eq("R6", "bus released", int'(bus_held), 0);
        put_ctl(16'h0000);
        tx_level = 3'd0;
    endtask

    task automatic t_data_nack();
        int s0 = n_send, k0 = n_nack, p0 = n_stop;
        put_cnt(16'd4);
        tx_level = 3'd4;
        nack_send_at = n_send + 2;
        put_ctl(16'h8603);
        quiet();
        nack_send_at = -1;
        chk_eq("R12", "sends stop at nack", n_send - s0, 2);
        chk_eq("R12", "nack pulse", n_nack - k0, 1);
        chk_eq("R12", "stop bit cleared", int'(ctl_q), 16'h8600);
        chk_eq("R12", "remain after nack", int'(remain_q), 2);
        chk_eq("R12", "no stop", n_stop - p0, 0);
        put_ctl(16'h0000);
        tx_level = 3'd0;
    endtask

    task automatic t_repeat();
        int s0 = n_send, p0 = n_stop, a0 = n_ardy;
        put_cnt(16'd0);
        tx_level = 3'd3;
        put_ctl(16'h8605);
        quiet();
        chk_eq("R11", "sends until empty", n_send - s0, 3);
        chk_eq("R11", "remain untouched", int'(remain_q), 0);
        chk_eq("R11", "no ardy", n_ardy - a0, 0);
        chk_eq("R11", "no stop yet", n_stop - p0, 0);
        put_ctl(16'h8606);
        quiet();
        chk_eq("R11", "stop at once", n_stop - p0, 1);
        chk_eq("R11", "stop bit cleared", int'(ctl_q), 16'h8604);
        put_ctl(16'h0000);
    endtask

    task automatic t_disable();
        put_addr(7'h3C);
        put_cnt(16'd7);
        rx_level = 3'd4;
        put_ctl(16'h8401);
        quiet();
        chk_eq("R3", "held before disable", int'(bus_held), 1);
        chk_eq("R3", "remain before disable", int'(remain_q), 7);
        put_ctl(16'h0000);
        quiet();
        chk_eq("R3", "ctl cleared", int'(ctl_q), 0);
        chk_eq("R3", "remain cleared", int'(remain_q), 0);
        chk_eq("R3", "bus released", int'(bus_held), 0);
        put_ctl(16'h8401);
        quiet();
        chk_eq("R3", "address cleared", last_addr, 0);
        chk_eq("R3", "count cleared", int'(remain_q), 0);
        put_ctl(16'h0000);
        rx_level = 3'd0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        t_reset();
        t_mask();
        t_no_start();
        t_tx_count_stop();
        t_rx_count_ardy();
        t_start_nack();
        t_data_nack();
        t_repeat();
        t_disable();
        finish_run();
    end
endmodule